// File: doc/BRIEF.md
# Event Input Glitch Filter

This block conditions a slow, asynchronous external input before it reaches an event counter. The raw pin is first brought into the system clock domain through a two-flop synchroniser. An optional filter then holds back any new level until it has stayed unchanged across two falling edges of a slow sampling tick, nominally 2,048 Hz. With a 32.768 kHz base clock, this setting rejects pulses of 0.48 ms or less and always passes pulses of 0.98 ms or more. A final stage picks the rising or the falling edge of the resulting level and produces a single-cycle count strobe.

The counter that consumes the strobe configures the block with three static controls: a filter enable, an edge select and an event-mode enable. The sampling tick is a level input produced elsewhere. Its falling edges, seen as high in one clock cycle and low in the next, are the filter's sampling instants.

Top module: `evt_event_filter`

## Requirements
- R1: After synchronous reset `count_stb` is low, and the accepted input level is low.
- R2: The pin passes through exactly two synchroniser flops. With the filter off and the matching edge selected, `count_stb` is high in the third clock cycle after the cycle in which `pin_raw` changed.
- R3: With `filt_on` = 0 the synchronised level drives the edge stage directly, so even a two-cycle pulse on the pin gives its strobe.
- R4: `rise_sel` = 1 counts rising edges of the conditioned level and `rise_sel` = 0 counts falling edges; changing `rise_sel` while the level is steady gives no strobe.
- R5: While `event_mode` = 0 no strobe is produced, and raising `event_mode` while the level is steady gives no strobe.
- R6: With `filt_on` = 1 a changed synchronised level becomes the accepted level at the second falling edge of `tick_2k` at which it still differs from the accepted level. The strobe for that change is high in the following cycle, and the accepted level never moves at any other cycle.
- R7: With `filt_on` = 1 a pin pulse that lasts no more than one `tick_2k` period never produces a strobe.
- R8: With `filt_on` = 1 a pin pulse that lasts at least two `tick_2k` periods always produces its strobe.
- R9: If the synchronised level returns to the accepted level before the second tick falling edge, the pending count is cleared. A later change then needs two fresh tick falling edges.
- R10: `count_stb` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external event input |
| tick_2k | input | 1 | Slow sampling tick level; its falling edges are the filter's sampling instants |
| filt_on | input | 1 | 1 enables the two-tick glitch filter |
| rise_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| event_mode | input | 1 | 1 lets strobes through; 0 suppresses them |
| count_stb | output | 1 | One-cycle count strobe |

## Verification
Each expected strobe is predicted to the exact clock cycle from the tick schedule and the synchroniser latency. A design with an extra or a missing flop, or one that accepts a level at the first tick falling edge, therefore misses every prediction. Filtered pulses are placed to straddle exactly one tick falling edge, and also to fill a whole tick period. A filter that counts single edges or keeps the wrong window would let those pulses through as unexpected strobes. The discard case drives a short pulse, its reversal and then a new change before the next tick edge. A filter that keeps its pending count instead of clearing it fires sixteen cycles too early. Changes to the polarity, filter and mode controls while the level is steady would expose an edge stage that reacts to its controls rather than to the level.

// File: rtl/evf_pkg.sv
package evf_pkg;

    // Which transition of the conditioned level is counted
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pick_e;

    // Previous and present conditioned level, as seen by the edge stage
    typedef struct packed {
        logic prev;
        logic cur;
    } lvl_pair_t;

    // Filter state: accepted level plus count of tick falling edges seen
    localparam int unsigned MAX_FALLS = 15;

    function automatic logic edge_hit(lvl_pair_t p, edge_pick_e sel);
        if (sel == EDGE_RISE)
            return p.cur & ~p.prev;
        else
            return ~p.cur & p.prev;
    endfunction

endpackage

// File: rtl/evf_sync.sv
module evf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    initial begin
        assert_stage_count_R2: assert (STAGES >= 2)
            else $error("synchroniser needs at least two flops");
    end
endmodule

// File: rtl/evf_filter.sv
module evf_filter
    import evf_pkg::*;
#(
    parameter int unsigned FALLS_REQ = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic raw,
    output logic lvl
);
    localparam int unsigned CW = $clog2(FALLS_REQ + 1);
    localparam logic [CW-1:0] LAST = CW'(FALLS_REQ - 1);

    typedef struct packed {
        logic          acc;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st;
    logic        tick_q;
    logic        tick_fall;

    assign tick_fall = tick_q & ~tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
            st     <= '0;
        end else begin
            tick_q <= tick;
            if (!en) begin
                st.acc <= raw;
                st.cnt <= '0;
            end else if (raw == st.acc) begin
                st.cnt <= '0;
            end else if (tick_fall) begin
                if (st.cnt == LAST) begin
                    st.acc <= raw;
                    st.cnt <= '0;
                end else begin
                    st.cnt <= st.cnt + CW'(1);
                end
            end
        end
    end

    assign lvl = en ? st.acc : raw;

    initial begin
        assert_falls_range_R6: assert (FALLS_REQ >= 1 && FALLS_REQ <= MAX_FALLS)
            else $error("filter edge count out of range");
    end

    // Accepted level may move only at a tick falling edge while filtering
    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (rst)
        en && !tick_fall |=> $stable(st.acc));

    // A return to the accepted level clears the pending count
    assert_pending_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        en && (raw == st.acc) |=> st.cnt == '0);

    // Count never runs past the acceptance point
    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= LAST);
endmodule

// File: rtl/evf_edge.sv
module evf_edge
    import evf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  edge_pick_e pick,
    input  logic       mode,
    output logic       stb
);
    logic      prev_q;
    lvl_pair_t pair;

    always_comb begin
        pair.prev = prev_q;
        pair.cur  = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stb    <= 1'b0;
        end else begin
            prev_q <= lvl;
            stb    <= mode & edge_hit(pair, pick);
        end
    end

    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    assert_mode_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !mode |=> !stb);

    assert_rise_counted_R4: assert property (@(posedge clk) disable iff (rst)
        mode && (pick == EDGE_RISE) && $rose(lvl) |=> stb);

    assert_fall_counted_R4: assert property (@(posedge clk) disable iff (rst)
        mode && (pick == EDGE_FALL) && $fell(lvl) |=> stb);
endmodule

// File: rtl/evt_event_filter.sv
module evt_event_filter
    import evf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FALLS_REQ   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic tick_2k,
    input  logic filt_on,
    input  logic rise_sel,
    input  logic event_mode,
    output logic count_stb
);
    logic pin_sync;
    logic lvl_cond;

    evf_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_sync)
    );

    evf_filter #(.FALLS_REQ(FALLS_REQ)) i_filter (
        .clk  (clk),
        .rst  (rst),
        .en   (filt_on),
        .tick (tick_2k),
        .raw  (pin_sync),
        .lvl  (lvl_cond)
    );

    evf_edge i_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_cond),
        .pick (edge_pick_e'(rise_sel)),
        .mode (event_mode),
        .stb  (count_stb)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !count_stb);
endmodule

// File: tb/test_evt_event_filter.sv
`timescale 1ns/1ps
module test_evt_event_filter;
    localparam int TPER = 16;   // tick period in clock cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic tick = 1'b1;
    logic filt = 1'b0;
    logic pol = 1'b0;
    logic mode = 1'b0;
    logic stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    typedef struct {
        int    at;
        string req;
    } exp_t;
    exp_t q[$];

    evt_event_filter i_evt_event_filter (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin),
        .tick_2k    (tick),
        .filt_on    (filt),
        .rise_sel   (pol),
        .event_mode (mode),
        .count_stb  (stb)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick high for half a period, low for the other half; falls seen at posedge cyc%16==9
    always @(negedge clk) tick <= ((cyc % TPER) < TPER / 2);

    function automatic int next_fall(int c);
        int p = c;
        while (p % TPER != 9) p++;
        return p;
    endfunction

    task automatic expect_at(int at, string req);
        exp_t e;
        e.at = at;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align(int off);
        while (cyc % TPER != off) @(negedge clk);
    endtask

    task automatic drain(string req);
        for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
        settle(60);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d strobes outstanding, expected 0", req, q.size());
            q.delete();
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (q.size() != 0 && cyc > q[0].at) begin
                checks++;
                errors++;
                $display("FAIL %s: no strobe by cycle %0d, expected at %0d", q[0].req, cyc, q[0].at);
                void'(q.pop_front());
            end
            if (stb) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: strobe at cycle %0d, expected none", cur_req, cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.at != cyc) begin
                        errors++;
                        $display("FAIL %s: strobe at cycle %0d, expected %0d", e.req, cyc, e.at);
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        settle(4);
        checks++;   // R1 reset state
        if (stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: strobe %b during reset, expected 0", stb);
        end
        rst = 1'b0;
        settle(6);
        checks++;   // R1 quiet after release
        if (stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: strobe %b after reset, expected 0", stb);
        end

        // R2/R3: unfiltered, falling edges
        cur_req = "R2"; mode = 1'b1; filt = 1'b0; pol = 1'b0;
        settle(4);
        pin = 1'b1; settle(10);
        k = cyc; pin = 1'b0; expect_at(k + 3, "R2");
        settle(10);
        cur_req = "R3";
        pin = 1'b1; settle(10);
        k = cyc; pin = 1'b0; expect_at(k + 3, "R3");
        settle(2);
        pin = 1'b1; settle(2);
        k = cyc; pin = 1'b0; expect_at(k + 3, "R3");
        drain("R3");

        // R4: polarity change alone, then rising edges counted
        cur_req = "R4";
        pol = 1'b1; settle(10);
        k = cyc; pin = 1'b1; expect_at(k + 3, "R4");
        settle(10);
        pol = 1'b0; settle(10);
        pol = 1'b1; settle(10);
        pin = 1'b0;
        drain("R4");

        // R5: mode off suppresses strobes; enabling while steady is quiet
        cur_req = "R5";
        mode = 1'b0;
        for (int i = 0; i < 4; i++) begin
            pin = ~pin; settle(5);
        end
        pin = 1'b1; settle(10);
        mode = 1'b1;
        drain("R5");
        pin = 1'b0; settle(10);

        // R7: filtered, short pulses rejected
        cur_req = "R7";
        filt = 1'b1; pol = 1'b1;
        settle(20);
        align(0);
        pin = 1'b1; settle(10); pin = 1'b0;   // straddles one tick fall
        settle(40);
        align(5);
        pin = 1'b1; settle(TPER); pin = 1'b0; // full tick period
        drain("R7");

        // R6/R8: filtered long pulse, rising edge
        cur_req = "R8";
        align(3);
        k = cyc; pin = 1'b1; expect_at(next_fall(k + 3) + TPER + 1, "R8");
        settle(2 * TPER + 8);
        pin = 1'b0;
        drain("R8");

        // R6: filtered, falling edge with exact acceptance timing
        cur_req = "R6";
        pol = 1'b0;
        settle(10);
        align(11);
        pin = 1'b1; settle(3 * TPER);
        k = cyc; pin = 1'b0; expect_at(next_fall(k + 3) + TPER + 1, "R6");
        drain("R6");

        // R9: pending count discarded when the level returns
        cur_req = "R9";
        pol = 1'b1;
        settle(10);
        align(0);
        pin = 1'b1; settle(10); pin = 1'b0;
        settle(10);
        k = cyc; pin = 1'b1; expect_at(next_fall(k + 3) + TPER + 1, "R9");
        settle(40);
        pin = 1'b0;
        drain("R9");

        // R5/R4: toggling filter enable with the level steady gives nothing
        cur_req = "R5";
        filt = 1'b0; settle(10);
        filt = 1'b1; settle(10);
        drain("R5");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule